// File: doc/BRIEF.md
# Branch-Aware Program Counter Unit

This block holds the program counter of a small single-cycle processor core and drives the address used for instruction fetch. On each clock edge it loads the next address. That address is either the next sequential word or a branch target relative to the program counter. The branch target is built from a 24-bit signed word offset carried in the branch instruction.

Executing instructions see the program counter as the fetch address plus eight, because of how the pipeline is staged. The block drives that value out so that it can be used where the program counter is read as an operand. Branch targets are measured from the same value. For a branch that saves a return address, the block drives out the address of the following instruction together with a write strobe, so that the link register can be loaded in the same cycle. Condition evaluation, the instruction memory and the register file sit outside this block.

Top module: `pc_steer`

## Requirements
- R1: A clock edge with `rst` high loads `fetch_addr` with 0x0000_0000.
- R2: A clock edge with `rst` low and `take_br` low loads `fetch_addr` with the old `fetch_addr` plus 4.
- R3: `exec_pc` always equals `fetch_addr` plus 8, modulo 2^32.
- R4: A clock edge with `rst` low and `take_br` high loads `fetch_addr` with (old `fetch_addr` + 8) + T. T is `br_off` with its bit 23 taken as the sign, shifted left by two places and sign-extended to 32 bits.
- R5: When `rst` and `take_br` are high in the same cycle, reset wins and `fetch_addr` becomes 0x0000_0000.
- R6: `link_we` is high exactly when `take_br` and `link_req` are both high and `rst` is low. `ret_addr` always equals `fetch_addr` plus 4.
- R7: `link_req` has no effect on the next `fetch_addr`. With `take_br` low it does not raise `link_we`.
- R8: All address sums wrap modulo 2^32, both above 0xFFFF_FFFF and below zero.
- R9: Bits [1:0] of `fetch_addr` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| take_br | input | 1 | Branch taken in this cycle |
| link_req | input | 1 | The branch saves a return address |
| br_off | input | 24 | Signed word offset of the branch |
| fetch_addr | output | 32 | Current program counter, used as the fetch address |
| exec_pc | output | 32 | Program counter as seen by executing instructions (fetch_addr + 8) |
| ret_addr | output | 32 | Return address for linking (fetch_addr + 4) |
| link_we | output | 1 | Write strobe for the return address |

## Verification
The next-address choice is driven with straight-line steps, forward and backward branches, a zero offset, an offset that lands on its own instruction, and both extreme offsets. These cases separate the +4 path from the +8 base and show whether the offset is sign-extended and scaled. A link request without a branch shows that linking never alters the next address. Reset asserted together with a branch shows which of the two takes priority. A backward branch from address zero, followed by straight-line steps past the top of the address space, checks that every sum wraps.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned OFF_W_DEF  = 24;
  localparam int unsigned STEP_DEF   = 4;

  typedef enum logic {
    NXT_SEQ    = 1'b0,
    NXT_BRANCH = 1'b1
  } nxt_sel_e;
endpackage

// File: rtl/pc_arith.sv
module pc_arith #(
  parameter int unsigned AW   = 32,
  parameter int unsigned OW   = 24,
  parameter int unsigned STEP = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] seq_o,
  output logic [AW-1:0] exec_o,
  output logic [AW-1:0] tgt_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam int unsigned   PAD    = AW - OW - 2;

  logic [AW-1:0] disp_w;

  function automatic logic [AW-1:0] f_seq(input logic [AW-1:0] pc);
    return pc + STEP_V;
  endfunction

  function automatic logic [AW-1:0] f_exec(input logic [AW-1:0] pc);
    return pc + STEP_V + STEP_V;
  endfunction

  function automatic logic [AW-1:0] f_target(input logic [AW-1:0] pc,
                                             input logic [AW-1:0] disp);
    return f_exec(pc) + disp;
  endfunction

  generate
    if (AW > OW + 2) begin : g_extend
      assign disp_w = {{PAD{off_i[OW-1]}}, off_i, 2'b00};
    end else begin : g_exact
      assign disp_w = {off_i, 2'b00};
    end
  endgenerate

  assign seq_o  = f_seq(pc_i);
  assign exec_o = f_exec(pc_i);
  assign tgt_o  = f_target(pc_i, disp_w);
endmodule

// File: rtl/pc_sel.sv
module pc_sel
  import pc_steer_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          branch_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] tgt_i,
  output nxt_sel_e      sel_o,
  output logic [AW-1:0] next_o
);
  always_comb begin
    sel_o = branch_i ? NXT_BRANCH : NXT_SEQ;
    unique case (sel_o)
      NXT_BRANCH: next_o = tgt_i;
      default:    next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/pc_hold.sv
module pc_hold #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] next_i,
  output logic [AW-1:0] pc_o
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) pc_o <= RESET_PC;
    else     pc_o <= next_i;
  end

  // R1 / R5: after any reset edge the register holds the reset address
  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_value_R1: assert (pc_o == $past(RESET_PC))
        else $error("pc not at reset value after reset");
    end
  end

  assert_word_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned OFF_W  = OFF_W_DEF,
  parameter int unsigned STEP   = STEP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_br,
  input  logic              link_req,
  input  logic [OFF_W-1:0]  br_off,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] exec_pc,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              link_we
);
  localparam logic [ADDR_W-1:0] RESET_PC = '0;
  localparam logic [ADDR_W-1:0] STEP_V   = ADDR_W'(STEP);

  logic [ADDR_W-1:0] seq_w;
  logic [ADDR_W-1:0] tgt_w;
  logic [ADDR_W-1:0] next_w;
  nxt_sel_e          sel_w;

  pc_arith #(.AW(ADDR_W), .OW(OFF_W), .STEP(STEP)) u_arith (
    .pc_i   (fetch_addr),
    .off_i  (br_off),
    .seq_o  (seq_w),
    .exec_o (exec_pc),
    .tgt_o  (tgt_w)
  );

  pc_sel #(.AW(ADDR_W)) u_sel (
    .branch_i (take_br),
    .seq_i    (seq_w),
    .tgt_i    (tgt_w),
    .sel_o    (sel_w),
    .next_o   (next_w)
  );

  pc_hold #(.AW(ADDR_W), .RESET_PC(RESET_PC)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .next_i (next_w),
    .pc_o   (fetch_addr)
  );

  assign ret_addr = seq_w;
  assign link_we  = take_br & link_req & ~rst;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_w == NXT_SEQ) |=> fetch_addr == $past(fetch_addr) + STEP_V);

  assert_exec_view_R3: assert property (@(posedge clk) disable iff (rst)
    exec_pc == fetch_addr + STEP_V + STEP_V);

  assert_branch_load_R4: assert property (@(posedge clk) disable iff (rst)
    take_br |=> fetch_addr == $past(tgt_w));

  assert_link_addr_R6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (ret_addr == fetch_addr + STEP_V) && take_br);

  assert_link_needs_branch_R7: assert property (@(posedge clk) disable iff (rst)
    !take_br |-> !link_we);
endmodule

// File: tb/pc_steer_test.sv
module pc_steer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_br = 1'b0;
  logic        link_req = 1'b0;
  logic [23:0] br_off = '0;
  logic [31:0] fetch_addr, exec_pc, ret_addr;
  logic        link_we;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] mpc;

  always #5 clk = ~clk;

  pc_steer uut (
    .clk(clk), .rst(rst), .take_br(take_br), .link_req(link_req),
    .br_off(br_off), .fetch_addr(fetch_addr), .exec_pc(exec_pc),
    .ret_addr(ret_addr), .link_we(link_we)
  );

  // {take, link, offset}
  localparam logic [25:0] VEC [0:9] = '{
    {1'b0, 1'b0, 24'h000000},
    {1'b0, 1'b1, 24'h000000},
    {1'b1, 1'b0, 24'h000004},
    {1'b1, 1'b1, 24'hFFFFFE},
    {1'b1, 1'b0, 24'h000000},
    {1'b1, 1'b0, 24'hFFFFFE},
    {1'b0, 1'b0, 24'h000000},
    {1'b1, 1'b1, 24'h7FFFFF},
    {1'b1, 1'b0, 24'h800000},
    {1'b0, 1'b1, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle (called just after a falling edge), check comb outputs,
  // then check the register after the rising edge
  task automatic step(input logic tk, input logic lk, input logic [23:0] off);
    logic [31:0] nxt;
    take_br = tk; link_req = lk; br_off = off;
    #1;
    chk("R3 exec_pc", exec_pc, mpc + 32'd8);
    chk("R6 ret_addr", ret_addr, mpc + 32'd4);
    chk(lk && !tk ? "R7 link_we" : "R6 link_we", {31'b0, link_we}, {31'b0, tk & lk});
    if (tk) nxt = mpc + 32'd8 + {{6{off[23]}}, off, 2'b00};
    else    nxt = mpc + 32'd4;
    @(posedge clk); #1;
    mpc = nxt;
    chk(tk ? "R4 branch target" : (lk ? "R7 link no effect" : "R2 sequential"), fetch_addr, mpc);
    chk("R9 low bits", {30'b0, fetch_addr[1:0]}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // reset with a branch request pending: R1, R5
    rst = 1'b1; take_br = 1'b1; link_req = 1'b1; br_off = 24'h000010;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset value", fetch_addr, 32'h0);
    chk("R5 reset over branch", fetch_addr, 32'h0);
    chk("R6 no link in reset", {31'b0, link_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    mpc = 32'h0;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][25], VEC[i][24], VEC[i][23:0]);
    end

    // mid-run reset against a branch: R5
    rst = 1'b1; take_br = 1'b1; br_off = 24'h000100;
    @(posedge clk); #1;
    chk("R5 reset over branch mid-run", fetch_addr, 32'h0);
    @(negedge clk);
    rst = 1'b0; mpc = 32'h0;

    // wrap below zero and past the top: R8
    step(1'b1, 1'b0, 24'hFFFFFC);
    chk("R8 wrap below zero", fetch_addr, 32'hFFFF_FFF8);
    step(1'b0, 1'b0, 24'h0);
    chk("R8 step to top", fetch_addr, 32'hFFFF_FFFC);
    #1;
    chk("R8 exec_pc wrap", exec_pc, 32'h0000_0004);
    chk("R8 ret_addr wrap", ret_addr, 32'h0000_0000);
    step(1'b0, 1'b0, 24'h0);
    chk("R8 wrap past top", fetch_addr, 32'h0000_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule